// File: doc/BRIEF.md
# Instruction Group Register Hazard Checker

This block examines one instruction group of up to `SLOTS` slots, all presented side by side in a single cycle, and reports whether the group breaks the register dependency rules that make parallel and serial execution of the group give the same result. Each slot supplies an enable from its qualifying predicate. It also supplies a list of source register identifiers and a list of destination register identifiers, each with its own valid bit. The operand lists carry every register the slot touches, including application and control registers used without being named. These implicit accesses are therefore checked exactly like explicit operands.

A register identifier is `2 + NUM_W` bits wide. The upper two bits select the register file: 0 general, 1 floating, 2 predicate, 3 application/control. The lower `NUM_W` bits hold the register number. The block flags a later slot reading a register that an earlier slot writes (RAW), and two slots writing the same register (WAW). A later write to a register an earlier slot reads (WAR) is legal. Predicate register 0 never takes part. The block never sees memory accesses, so memory ordering within the group can never raise a flag.

In the same cycle the block also picks the earliest slot among per-slot exception inputs. All results are registered and appear one clock after the strobe.

Top module: `igdc_check`

## Requirements
- R1: When `in_valid` is high and an enabled slot j reads (valid source) an identifier that an enabled slot i < j writes (valid destination), `viol` is 1 on the next cycle.
- R2: Two enabled slots that both write the same identifier set `viol` to 1. If the reported pair has no RAW match, `viol_kind` is 1 (WAW).
- R3: A later slot writing an identifier that only an earlier slot reads (WAR) does not set `viol`.
- R4: A slot with `slot_en` low is neither reader nor writer in any comparison. With all `slot_en` low, `viol` is 0.
- R5: Identifier file 2 number 0 (predicate register zero) never matches anything, as source or destination.
- R6: Identifiers match only if both file and number are equal. The same number in different files never matches.
- R7: `viol_early`/`viol_late` give the violating pair with the lowest earlier index, and among those the lowest later index. `viol_kind` is 0 (RAW) if that pair has a RAW match, otherwise 1. With no violation all three are 0.
- R8: `exc_any` is the OR of `exc_in`. `exc_slot` is the index of the lowest set bit of `exc_in`, or 0 when none is set.
- R9: Results appear exactly one cycle after `in_valid` is high, with `out_valid` high for that one cycle. Without `in_valid`, the result outputs hold and `out_valid` is 0.
- R10: A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: a group is presented this cycle |
| slot_en | input | SLOTS | Per-slot enable from its qualifying predicate |
| src_valid | input | SLOTS*NSRC | Valid bit per source operand, slot-major |
| src_id | input | SLOTS*NSRC*ID_W | Source identifiers {file, number}, slot-major |
| dst_valid | input | SLOTS*NDST | Valid bit per destination operand, slot-major |
| dst_id | input | SLOTS*NDST*ID_W | Destination identifiers {file, number}, slot-major |
| exc_in | input | SLOTS | Per-slot exception raised |
| out_valid | output | 1 | Results updated this cycle |
| viol | output | 1 | Dependency violation found |
| viol_early | output | SLOT_W | Earlier slot of the reported pair |
| viol_late | output | SLOT_W | Later slot of the reported pair |
| viol_kind | output | 1 | 0 RAW, 1 WAW |
| exc_any | output | 1 | Some slot raised an exception |
| exc_slot | output | SLOT_W | Earliest excepting slot |

## Verification
The assertions assume that `slot_en`, the operand vectors and `exc_in` are stable and known in the cycle where `in_valid` is high. Their `$past` checks of `exc_in` depend on this. They also assume that slots are numbered in program order, so slot 0 is the earliest. The stimulus changes inputs only on the falling edge and pulses `in_valid` for one cycle per group. It draws identifiers from a tiny space (all four files, numbers 0 and 1), so matches, predicate-zero collisions and cross-file near misses turn up often.

// File: rtl/igdc_pkg.sv
package igdc_pkg;
  typedef enum logic [1:0] {
    RF_GEN  = 2'd0,
    RF_FLT  = 2'd1,
    RF_PRED = 2'd2,
    RF_APP  = 2'd3
  } reg_file_e;

  typedef enum logic {
    VK_RAW = 1'b0,
    VK_WAW = 1'b1
  } viol_kind_e;
endpackage

// File: rtl/igdc_pair_cmp.sv
module igdc_pair_cmp
  import igdc_pkg::*;
#(
  parameter int NSRC  = 3,
  parameter int NDST  = 2,
  parameter int NUM_W = 7,
  localparam int ID_W = NUM_W + 2
) (
  input  logic                 en_early,
  input  logic                 en_late,
  input  logic [NDST-1:0]      e_dst_v,
  input  logic [NDST*ID_W-1:0] e_dst,
  input  logic [NSRC-1:0]      l_src_v,
  input  logic [NSRC*ID_W-1:0] l_src,
  input  logic [NDST-1:0]      l_dst_v,
  input  logic [NDST*ID_W-1:0] l_dst,
  output logic                 raw_hit,
  output logic                 waw_hit
);
  // predicate register zero is exempt from every comparison
  function automatic logic counts(input logic [ID_W-1:0] id);
    return !((id[ID_W-1 -: 2] == RF_PRED) && (id[NUM_W-1:0] == '0));
  endfunction

  logic both_on;
  assign both_on = en_early & en_late;

  always_comb begin
    raw_hit = 1'b0;
    waw_hit = 1'b0;
    for (int a = 0; a < NDST; a++) begin
      for (int b = 0; b < NSRC; b++) begin
        if (both_on && e_dst_v[a] && l_src_v[b] &&
            e_dst[a*ID_W +: ID_W] == l_src[b*ID_W +: ID_W] &&
            counts(e_dst[a*ID_W +: ID_W]))
          raw_hit = 1'b1;
      end
      for (int c = 0; c < NDST; c++) begin
        if (both_on && e_dst_v[a] && l_dst_v[c] &&
            e_dst[a*ID_W +: ID_W] == l_dst[c*ID_W +: ID_W] &&
            counts(e_dst[a*ID_W +: ID_W]))
          waw_hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/igdc_pick.sv
module igdc_pick
  import igdc_pkg::*;
#(
  parameter int SLOTS = 3,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS*SLOTS-1:0] raw_m,
  input  logic [SLOTS*SLOTS-1:0] waw_m,
  output logic                   hit,
  output logic [SLOT_W-1:0]      early,
  output logic [SLOT_W-1:0]      late,
  output logic                   kind
);
  // scan earlier index first, then later index; RAW outranks WAW on a pair
  always_comb begin
    hit   = 1'b0;
    early = '0;
    late  = '0;
    kind  = VK_RAW;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = 0; j < SLOTS; j++) begin
        if (!hit && (raw_m[i*SLOTS+j] || waw_m[i*SLOTS+j])) begin
          hit   = 1'b1;
          early = SLOT_W'(i);
          late  = SLOT_W'(j);
          kind  = raw_m[i*SLOTS+j] ? VK_RAW : VK_WAW;
        end
      end
    end
  end
endmodule

// File: rtl/igdc_first_exc.sv
module igdc_first_exc #(
  parameter int SLOTS = 3,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]  exc,
  output logic              any,
  output logic [SLOT_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!any && exc[s]) begin
        any = 1'b1;
        idx = SLOT_W'(s);
      end
    end
  end
endmodule

// File: rtl/igdc_check.sv
module igdc_check
  import igdc_pkg::*;
#(
  parameter int SLOTS = 3,
  parameter int NSRC  = 3,
  parameter int NDST  = 2,
  parameter int NUM_W = 7,
  localparam int ID_W   = NUM_W + 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [SLOTS-1:0]           slot_en,
  input  logic [SLOTS*NSRC-1:0]      src_valid,
  input  logic [SLOTS*NSRC*ID_W-1:0] src_id,
  input  logic [SLOTS*NDST-1:0]      dst_valid,
  input  logic [SLOTS*NDST*ID_W-1:0] dst_id,
  input  logic [SLOTS-1:0]           exc_in,
  output logic                       out_valid,
  output logic                       viol,
  output logic [SLOT_W-1:0]          viol_early,
  output logic [SLOT_W-1:0]          viol_late,
  output logic                       viol_kind,
  output logic                       exc_any,
  output logic [SLOT_W-1:0]          exc_slot
);
  logic [SLOTS*SLOTS-1:0] raw_m;
  logic [SLOTS*SLOTS-1:0] waw_m;

  // slot 0 never reads after an earlier slot, so its sources are not compared
  logic unused_lead_src;
  assign unused_lead_src = ^{src_valid[NSRC-1:0], src_id[NSRC*ID_W-1:0]};

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_early
    for (genvar gj = 0; gj < SLOTS; gj++) begin : g_late
      if (gi < gj) begin : g_cmp
        igdc_pair_cmp #(.NSRC(NSRC), .NDST(NDST), .NUM_W(NUM_W)) u_cmp (
          .en_early (slot_en[gi]),
          .en_late  (slot_en[gj]),
          .e_dst_v  (dst_valid[gi*NDST +: NDST]),
          .e_dst    (dst_id[gi*NDST*ID_W +: NDST*ID_W]),
          .l_src_v  (src_valid[gj*NSRC +: NSRC]),
          .l_src    (src_id[gj*NSRC*ID_W +: NSRC*ID_W]),
          .l_dst_v  (dst_valid[gj*NDST +: NDST]),
          .l_dst    (dst_id[gj*NDST*ID_W +: NDST*ID_W]),
          .raw_hit  (raw_m[gi*SLOTS+gj]),
          .waw_hit  (waw_m[gi*SLOTS+gj])
        );
      end else begin : g_none
        assign raw_m[gi*SLOTS+gj] = 1'b0;
        assign waw_m[gi*SLOTS+gj] = 1'b0;
      end
    end
  end

  logic              hit_c, kind_c, exc_any_c;
  logic [SLOT_W-1:0] early_c, late_c, exc_idx_c;

  igdc_pick #(.SLOTS(SLOTS)) u_pick (
    .raw_m (raw_m),
    .waw_m (waw_m),
    .hit   (hit_c),
    .early (early_c),
    .late  (late_c),
    .kind  (kind_c)
  );

  igdc_first_exc #(.SLOTS(SLOTS)) u_exc (
    .exc (exc_in),
    .any (exc_any_c),
    .idx (exc_idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      viol       <= 1'b0;
      viol_early <= '0;
      viol_late  <= '0;
      viol_kind  <= 1'b0;
      exc_any    <= 1'b0;
      exc_slot   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        viol       <= hit_c;
        viol_early <= early_c;
        viol_late  <= late_c;
        viol_kind  <= kind_c;
        exc_any    <= exc_any_c;
        exc_slot   <= exc_idx_c;
      end
    end
  end

  // R9: one result per strobe, outputs frozen otherwise
  assert_result_follows_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_result_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(viol) && $stable(viol_early) &&
                   $stable(viol_late) && $stable(exc_slot)));
  // R4: no enabled slot, no violation
  assert_disabled_group_clean_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && slot_en == '0) |=> !viol);
  // R7: reported pair ordering and quiet fields
  assert_pair_ordered_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && viol) |-> (viol_early < viol_late));
  assert_quiet_when_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !viol) |-> (viol_early == '0 && viol_late == '0 && viol_kind == 1'b0));
  // R8: reported slot raised and nothing earlier did
  assert_exc_slot_raised_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc_any) |-> ((($past(exc_in) >> exc_slot) & SLOTS'(1)) != '0));
  assert_exc_slot_earliest_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc_any) |-> (($past(exc_in) & ((SLOTS'(1) << exc_slot) - SLOTS'(1))) == '0));
  assert_exc_none_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !exc_any) |-> ($past(exc_in) == '0 && exc_slot == '0));
endmodule

// File: tb/igdc_check_bench.sv
module igdc_check_bench;
  localparam int SLOTS = 3;
  localparam int NSRC  = 3;
  localparam int NDST  = 2;
  localparam int NUM_W = 7;
  localparam int ID_W  = NUM_W + 2;
  localparam int SLOT_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [SLOTS-1:0]           slot_en = '0;
  logic [SLOTS*NSRC-1:0]      src_valid = '0;
  logic [SLOTS*NSRC*ID_W-1:0] src_id = '0;
  logic [SLOTS*NDST-1:0]      dst_valid = '0;
  logic [SLOTS*NDST*ID_W-1:0] dst_id = '0;
  logic [SLOTS-1:0]           exc_in = '0;
  logic              out_valid, viol, viol_kind, exc_any;
  logic [SLOT_W-1:0] viol_early, viol_late, exc_slot;

  always #2.5 clk = ~clk;

  igdc_check #(.SLOTS(SLOTS), .NSRC(NSRC), .NDST(NDST), .NUM_W(NUM_W)) u_igdc_check (
    .clk(clk), .rst(rst), .in_valid(in_valid), .slot_en(slot_en),
    .src_valid(src_valid), .src_id(src_id), .dst_valid(dst_valid), .dst_id(dst_id),
    .exc_in(exc_in), .out_valid(out_valid), .viol(viol), .viol_early(viol_early),
    .viol_late(viol_late), .viol_kind(viol_kind), .exc_any(exc_any), .exc_slot(exc_slot)
  );

  int checks = 0;
  int fails  = 0;
  int e_viol, e_early, e_late, e_kind, e_exc_any, e_exc_slot;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [ID_W-1:0] mk(input int file, input int num);
    return {2'(file), NUM_W'(num)};
  endfunction

  task automatic clear_all();
    slot_en = '1; src_valid = '0; src_id = '0; dst_valid = '0; dst_id = '0; exc_in = '0;
  endtask

  task automatic put_src(input int s, input int k, input logic [ID_W-1:0] id);
    src_valid[s*NSRC+k] = 1'b1;
    src_id[(s*NSRC+k)*ID_W +: ID_W] = id;
  endtask

  task automatic put_dst(input int s, input int k, input logic [ID_W-1:0] id);
    dst_valid[s*NDST+k] = 1'b1;
    dst_id[(s*NDST+k)*ID_W +: ID_W] = id;
  endtask

  function automatic bit same(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    if (a[ID_W-1 -: 2] == 2'd2 && a[NUM_W-1:0] == '0) return 1'b0;
    return a == b;
  endfunction

  // expected results worked out from the requirements
  task automatic model();
    bit found = 0;
    e_viol = 0; e_early = 0; e_late = 0; e_kind = 0; e_exc_any = 0; e_exc_slot = 0;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = i + 1; j < SLOTS; j++) begin
        bit r = 0, w = 0;
        if (slot_en[i] && slot_en[j]) begin
          for (int a = 0; a < NDST; a++) begin
            if (dst_valid[i*NDST+a]) begin
              for (int b = 0; b < NSRC; b++)
                if (src_valid[j*NSRC+b] && same(dst_id[(i*NDST+a)*ID_W +: ID_W],
                                                src_id[(j*NSRC+b)*ID_W +: ID_W])) r = 1;
              for (int c = 0; c < NDST; c++)
                if (dst_valid[j*NDST+c] && same(dst_id[(i*NDST+a)*ID_W +: ID_W],
                                                dst_id[(j*NDST+c)*ID_W +: ID_W])) w = 1;
            end
          end
        end
        if (!found && (r || w)) begin
          found = 1; e_viol = 1; e_early = i; e_late = j; e_kind = r ? 0 : 1;
        end
      end
    end
    for (int s = SLOTS - 1; s >= 0; s--)
      if (exc_in[s]) begin e_exc_any = 1; e_exc_slot = s; end
  endtask

  task automatic run_group(input string tag);
    model();
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk({tag, " R9 out_valid"}, out_valid, 1);
    chk({tag, " R1 viol"}, viol, e_viol);
    chk({tag, " R2 kind"}, viol_kind, e_kind);
    chk({tag, " R7 early"}, viol_early, e_early);
    chk({tag, " R7 late"}, viol_late, e_late);
    chk({tag, " R8 exc_any"}, exc_any, e_exc_any);
    chk({tag, " R8 exc_slot"}, exc_slot, e_exc_slot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid", out_valid, 0);
    chk("R10 viol", viol, 0);
    chk("R10 exc_any", exc_any, 0);
    chk("R10 exc_slot", exc_slot, 0);
    rst = 1'b0;

    clear_all(); put_dst(0, 1, mk(0, 5)); put_src(2, 2, mk(0, 5));
    run_group("R1 raw 0->2");
    chk("R1 flag", viol, 1);

    clear_all(); put_src(0, 0, mk(0, 5)); put_dst(1, 0, mk(0, 5));
    run_group("R3 war");
    chk("R3 no flag", viol, 0);

    clear_all(); put_dst(1, 0, mk(1, 3)); put_dst(2, 1, mk(1, 3));
    run_group("R2 waw");
    chk("R2 kind waw", viol_kind, 1);

    clear_all(); put_dst(0, 0, mk(0, 5)); put_src(2, 0, mk(0, 5)); slot_en = 3'b110;
    run_group("R4 disabled writer");
    chk("R4 no flag", viol, 0);

    clear_all(); put_dst(0, 0, mk(0, 5)); put_dst(1, 0, mk(0, 5)); slot_en = '0;
    run_group("R4 all disabled");
    chk("R4 none", viol, 0);

    clear_all(); put_dst(0, 0, mk(2, 0)); put_src(1, 0, mk(2, 0)); put_dst(1, 1, mk(2, 0));
    run_group("R5 pred zero");
    chk("R5 no flag", viol, 0);

    clear_all(); put_dst(0, 0, mk(2, 1)); put_src(1, 0, mk(2, 1));
    run_group("R5 pred one");
    chk("R5 flag", viol, 1);

    clear_all(); put_dst(0, 0, mk(0, 5)); put_src(1, 0, mk(1, 5)); put_dst(2, 0, mk(3, 5));
    run_group("R6 cross file");
    chk("R6 no flag", viol, 0);

    clear_all(); put_dst(1, 0, mk(0, 2)); put_dst(2, 0, mk(0, 2));
    put_dst(0, 1, mk(3, 9)); put_src(2, 1, mk(3, 9)); put_dst(2, 1, mk(3, 9));
    run_group("R7 priority");
    chk("R7 early", viol_early, 0);
    chk("R7 raw over waw", viol_kind, 0);

    clear_all(); exc_in = 3'b110;
    run_group("R8 exc");
    chk("R8 earliest", exc_slot, 1);

    // R9: inputs change without strobe, outputs must hold
    clear_all(); put_dst(0, 0, mk(0, 7)); put_src(1, 0, mk(0, 7)); exc_in = 3'b001;
    @(negedge clk); @(negedge clk);
    chk("R9 hold out_valid", out_valid, 0);
    chk("R9 hold viol", viol, 0);
    chk("R9 hold exc_slot", exc_slot, 1);

    // sweep with a tiny identifier space
    for (int n = 0; n < 1500; n++) begin
      clear_all();
      for (int s = 0; s < SLOTS; s++) begin
        for (int k = 0; k < NSRC; k++) begin
          lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
          src_valid[s*NSRC+k] = lfsr[3];
          src_id[(s*NSRC+k)*ID_W +: ID_W] = mk(int'(lfsr[1:0]), int'(lfsr[2]));
        end
        for (int k = 0; k < NDST; k++) begin
          lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
          dst_valid[s*NDST+k] = lfsr[3] & lfsr[4];
          dst_id[(s*NDST+k)*ID_W +: ID_W] = mk(int'(lfsr[1:0]), int'(lfsr[2]));
        end
        slot_en[s] = lfsr[5] | lfsr[6];
        exc_in[s]  = lfsr[7] & lfsr[8];
      end
      run_group("sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule